// File: doc/BRIEF.md
# Atomic Register-Memory Swap Sequencer

This block carries out one swap between the register file and memory. On a start pulse it takes the address from one register and the store value from another. It reads the memory location and then writes the store value to that same address. The value it loaded then goes to a third register. The read and the write form one locked pair, so no other bus master can get between them.

The block runs in word mode or byte mode. In byte mode one byte moves each way, and the loaded byte reaches the register zero-extended. In word mode the memory address has its low bits cleared. The loaded word is rotated right by eight times the low address bits before it is written back, which matches how the core loads unaligned words.

The register file is read combinationally on the start cycle. After that the block holds everything it needs in its own registers, so the opcode may change while a swap is running.

Top module: `swap_seq`

## Requirements
- R1: The opcode fields are fixed: base register index in bits 19:16, destination index in bits 15:12, source index in bits 3:0. Bit 22 selects byte mode (1) or word mode (0).
- R2: The access address is the base register's value as read at start, with no offset. The only register write is to the destination register.
- R3: Each swap makes exactly two memory accesses: a read (mem_we=0) and then a write (mem_we=1), both at the same mem_addr. Each request is held until mem_ack.
- R4: mem_lock is high in every cycle from the read request through the cycle of the write acknowledge.
- R5: In byte mode, mem_size=0 and mem_addr is the full address. mem_wdata is the source register's low byte with zero upper bits. The destination receives mem_rdata[7:0] zero-extended.
- R6: In word mode, mem_size=1 and mem_addr has its low two bits cleared. mem_wdata is the full source value. The destination receives mem_rdata rotated right by 8 × address[1:0].
- R7: The stored value is the source register as sampled at start. When the destination equals the source, memory still gets the old source value.
- R8: In the cycle after the write acknowledge, done and rf_we are high for exactly one cycle, with rf_widx equal to the destination index.
- R9: A start pulse while a swap is in progress is ignored. It causes no extra access, no extra register write and no extra done.
- R10: After reset, done, rf_we, mem_req and mem_lock are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a swap; accepted only when idle |
| opcode | input | 32 | Instruction word holding register fields and byte select |
| done | output | 1 | One-cycle pulse when the swap completes |
| rn_idx | output | 4 | Base register read index |
| rn_data | input | XLEN | Base register read data |
| rm_idx | output | 4 | Source register read index |
| rm_data | input | XLEN | Source register read data |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 4 | Register write index |
| rf_wdata | output | XLEN | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_size | output | 1 | Access size: 1 word, 0 byte |
| mem_lock | output | 1 | Bus lock across the read-write pair |
| mem_addr | output | XLEN | Memory address |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench builds the block with the default XLEN of 32. This width gives four byte lanes, so all four rotation amounts in word mode are tested, as are all four byte offsets in byte mode. The memory model acknowledges after a random delay of zero to two cycles. This varies how long each request and the lock are held. Register indices are drawn at random, which covers the overlapping-index cases where the destination equals the source or the base register.

// File: rtl/swap_seq.sv
module swap_seq #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     opcode,
  output logic            done,
  output logic [3:0]      rn_idx,
  input  logic [XLEN-1:0] rn_data,
  output logic [3:0]      rm_idx,
  input  logic [XLEN-1:0] rm_data,
  output logic            rf_we,
  output logic [3:0]      rf_widx,
  output logic [XLEN-1:0] rf_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_size,
  output logic            mem_lock,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack
);
  localparam int OFFW = $clog2(XLEN/8);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_WB} state_t;

  state_t          state;
  logic [XLEN-1:0] addr_q, src_q, load_q;
  logic [3:0]      rd_q;
  logic            byte_q;
  logic [2*XLEN-1:0] rot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      src_q  <= '0;
      load_q <= '0;
      rd_q   <= '0;
      byte_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q <= rn_data;
          src_q  <= rm_data;
          rd_q   <= opcode[15:12];
          byte_q <= opcode[22];
          state  <= S_READ;
        end
        S_READ: if (mem_ack) begin
          load_q <= mem_rdata;
          state  <= S_WRITE;
        end
        S_WRITE: if (mem_ack) state <= S_WB;
        S_WB:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rn_idx = opcode[19:16];
  assign rm_idx = opcode[3:0];

  assign mem_req   = (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_lock  = mem_req;
  assign mem_size  = !byte_q;
  assign mem_addr  = byte_q ? addr_q : {addr_q[XLEN-1:OFFW], {OFFW{1'b0}}};
  assign mem_wdata = byte_q ? {{(XLEN-8){1'b0}}, src_q[7:0]} : src_q;

  assign rot = {load_q, load_q} >> {addr_q[OFFW-1:0], 3'b000};

  assign done     = (state == S_WB);
  assign rf_we    = done;
  assign rf_widx  = rd_q;
  assign rf_wdata = byte_q ? {{(XLEN-8){1'b0}}, load_q[7:0]} : rot[XLEN-1:0];

  logic unused_bits;
  assign unused_bits = ^{opcode[31:23], opcode[21:20], opcode[11:4], rot[2*XLEN-1:XLEN]};
endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            rf_we,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_size,
  input logic            mem_lock,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_ack
);
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

  p_lock_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> mem_lock);

  p_word_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00));

  p_wb_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (done && rf_we && !mem_req));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!done && !rf_we && !mem_req && !mem_lock));
endmodule

bind swap_seq swap_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rf_we(rf_we), .mem_req(mem_req),
  .mem_we(mem_we), .mem_size(mem_size), .mem_lock(mem_lock),
  .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/swap_seq_tb.sv
module swap_seq_tb;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] opcode = 0;
  logic        done, rf_we, mem_req, mem_we, mem_size, mem_lock, mem_ack = 0;
  logic [3:0]  rn_idx, rm_idx, rf_widx;
  logic [31:0] rn_data, rm_data, rf_wdata, mem_addr, mem_wdata, mem_rdata = 0;

  int errors = 0, checks = 0;
  logic [31:0] rf [16];
  logic [31:0] mem [16];
  int n_acc = 0, n_wr = 0, n_done = 0, wait_cnt = 0;
  logic        acc_we [4];
  logic        acc_lock [4];
  logic [31:0] acc_addr [4];
  logic [31:0] acc_wdata [4];
  logic        lock_gap = 0;

  always #2 clk = ~clk;

  swap_seq u_dut (.*);

  assign rn_data = rf[rn_idx];
  assign rm_data = rf[rm_idx];

  always @(posedge clk) begin
    if (rf_we) begin rf[rf_widx] <= rf_wdata; n_wr <= n_wr + 1; end
    if (done) n_done <= n_done + 1;
    if (mem_req && mem_ack && n_acc < 4) begin
      acc_we[n_acc] <= mem_we; acc_addr[n_acc] <= mem_addr;
      acc_lock[n_acc] <= mem_lock; acc_wdata[n_acc] <= mem_wdata;
      n_acc <= n_acc + 1;
    end
    if (n_acc == 1 && !mem_lock) lock_gap <= 1;
  end

  always @(negedge clk) begin
    mem_ack <= 0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 0) begin
        mem_ack <= 1;
        if (mem_we) begin
          if (mem_size) mem[mem_addr[5:2]] = mem_wdata;
          else mem[mem_addr[5:2]][8*mem_addr[1:0] +: 8] = mem_wdata[7:0];
        end else begin
          if (mem_size) mem_rdata <= mem[mem_addr[5:2]];
          else mem_rdata <= {24'h0, mem[mem_addr[5:2]][8*mem_addr[1:0] +: 8]};
        end
        wait_cnt = $urandom % 3;
      end else wait_cnt = wait_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] v, input logic [1:0] o);
    logic [63:0] d = {v, v} >> (8 * o);
    return d[31:0];
  endfunction

  task automatic run_op(input logic [3:0] rn, input logic [3:0] rd, input logic [3:0] rm,
                        input bit bmode, input logic [5:0] a, input bit busy_start);
    logic [31:0] old_word, old_rm, exp_rd, exp_mem, exp_addr, old_rn;
    int cyc;
    for (int i = 0; i < 16; i++) begin rf[i] = $urandom; mem[i] = $urandom; end
    rf[rn] = {26'h0, a};
    old_word = mem[a[5:2]]; old_rm = rf[rm]; old_rn = rf[rn];
    exp_rd   = bmode ? {24'h0, old_word[8*a[1:0] +: 8]} : rotr(old_word, a[1:0]);
    exp_mem  = old_word;
    if (bmode) exp_mem[8*a[1:0] +: 8] = old_rm[7:0]; else exp_mem = old_rm;
    exp_addr = bmode ? {26'h0, a} : {26'h0, a[5:2], 2'b00};
    @(negedge clk);
    n_acc = 0; n_wr = 0; n_done = 0; lock_gap = 0;
    opcode = {8'hE1, 1'b0, bmode, 2'b00, rn, rd, 8'h09, rm};
    start = 1;
    @(negedge clk);
    start = 0;
    if (busy_start) begin
      opcode = {8'hE1, 1'b0, ~bmode, 2'b00, rm, rn, 8'h09, rd};
      start = 1;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk(done, "R8 done seen", {31'h0, done}, 1);
    chk(rf_widx == rd, "R8 write index", {28'h0, rf_widx}, {28'h0, rd});
    @(negedge clk);
    chk(!done, "R8 done one cycle", {31'h0, done}, 0);
    chk(rf[rd] == exp_rd, bmode ? "R5 byte load to Rd" : (rd == rm ? "R7 Rd=Rm load" : "R6 rotated load"), rf[rd], exp_rd);
    chk(mem[a[5:2]] == exp_mem, rd == rm ? "R7 stored old Rm" : (bmode ? "R5 byte store" : "R6 word store"), mem[a[5:2]], exp_mem);
    chk(n_acc == 2 && !acc_we[0] && acc_we[1], "R3 read then write", {acc_we[0], acc_we[1]}, 32'h1);
    chk(acc_addr[0] == exp_addr && acc_addr[1] == exp_addr, bmode ? "R5 address" : "R6 address", acc_addr[1], exp_addr);
    chk(acc_wdata[1] == (bmode ? {24'h0, old_rm[7:0]} : old_rm), "R5/R6 wdata R1", acc_wdata[1], bmode ? {24'h0, old_rm[7:0]} : old_rm);
    chk(acc_lock[0] && acc_lock[1] && !lock_gap, "R4 lock held", {acc_lock[0], acc_lock[1]}, 32'h3);
    if (rd != rn) chk(rf[rn] == old_rn, "R2 base untouched", rf[rn], old_rn);
    repeat (4) @(negedge clk);
    chk(n_acc == 2 && n_wr == 1 && n_done == 1,
        busy_start ? "R9 busy start ignored" : "R8 single write", n_acc * 256 + n_wr * 16 + n_done, 32'h211);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!done && !rf_we && !mem_req && !mem_lock, "R10 reset idle",
        {28'h0, done, rf_we, mem_req, mem_lock}, 0);
    rst_n = 1;
    for (int o = 0; o < 4; o++) run_op(4'd2, 4'd5, 4'd7, 0, 6'(20 + o), 0);
    for (int o = 0; o < 4; o++) run_op(4'd9, 4'd1, 4'd3, 1, 6'(40 + o), 0);
    run_op(4'd4, 4'd6, 4'd6, 0, 6'd13, 0);
    run_op(4'd4, 4'd6, 4'd6, 1, 6'd14, 0);
    run_op(4'd8, 4'd8, 4'd2, 0, 6'd7, 0);
    run_op(4'd0, 4'd15, 4'd11, 0, 6'd33, 1);
    run_op(4'd3, 4'd12, 4'd10, 1, 6'd61, 1);
    for (int k = 0; k < 40; k++)
      run_op(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 6'($urandom), (k % 7) == 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule